// File: doc/BRIEF.md
# Retransmission Descriptor Manager

This block keeps the bookkeeping for a ring of transmit packet slots whose contents have been sent but not yet confirmed by the receiver. Each time the data source reports that it has filled a slot, the block gives that slot the next stream packet number and asks the framer to send it. Acknowledgements from the receive parser free slots. They also expose losses early. Delivery is assumed to be in order in both directions. An acknowledgement for a packet newer than the oldest unconfirmed one therefore means the older unconfirmed packets were dropped, and they are queued again at once.

Every slot holds a repetition number. The number goes out with the packet and comes back in its acknowledgement. A skipped packet is only queued again when its own repetition number does not exceed the one carried by the acknowledgement. A packet that has already been resent after the acknowledged copy left is therefore not resent a second time. If no useful acknowledgement arrives for a set number of cycles while packets are outstanding, the oldest outstanding packet is resent. The data source is held off through a ready signal while every slot is occupied.

Top module: `retx_desc_mgr`

## Requirements
- R1: After reset no packet is outstanding: `free_rdy_o` is 1 and `tx_req_o` is 0.
- R2: A fill accepted while `free_rdy_o` is 1 takes the next packet number, counting up from 0 modulo 2^PKT_W. The packet uses slot (packet number mod NUM_SLOTS), starts with repetition number 0, and becomes pending for transmission on the next cycle.
- R3: `tx_req_o` is 1 whenever some outstanding packet is pending. `tx_pkt_o`, `tx_slot_o` and `tx_rep_o` describe the pending packet that is oldest in stream order. A cycle with `tx_req_o` and `tx_take_i` both at 1 clears that packet's pending state. Without `tx_take_i` the request stays.
- R4: An acknowledgement whose packet number lies in the outstanding window marks only that packet as confirmed and cancels its pending state. The oldest pointer then moves past every consecutive confirmed packet, which releases their slots.
- R5: An in-window acknowledgement for packet P with repetition number A re-queues each older outstanding packet that meets three conditions: it is unconfirmed, it is not pending, and its repetition number is at most A. Each such packet's repetition number goes up by one, saturating at 255.
- R6: In the case of R5, an older unconfirmed packet whose repetition number is above A, or that is already pending, keeps its state and repetition number.
- R7: An acknowledgement whose packet number, taken modulo 2^PKT_W relative to the oldest outstanding packet, is at or beyond the outstanding count has no effect.
- R8: After TIMEOUT_CYC consecutive cycles with packets outstanding and no in-window acknowledgement, the oldest outstanding packet is re-queued with its repetition number raised by one (unless it is already pending), and the count starts again.
- R9: With NUM_SLOTS packets outstanding, `free_rdy_o` is 0, a fill request is ignored, and the outstanding count never exceeds NUM_SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_i | input | 1 | Data source has filled the free slot |
| free_rdy_o | output | 1 | A slot is free for the data source |
| ack_vld_i | input | 1 | Acknowledgement present this cycle |
| ack_pkt_i | input | PKT_W | Acknowledged packet number |
| ack_rep_i | input | 8 | Repetition number echoed by the acknowledgement |
| tx_req_o | output | 1 | A packet is waiting to be framed |
| tx_take_i | input | 1 | Framer accepts the requested packet |
| tx_slot_o | output | SLOT_W | Slot of the requested packet |
| tx_pkt_o | output | PKT_W | Packet number of the requested packet |
| tx_rep_o | output | 8 | Repetition number to send with it |

## Verification
The bench aims at acknowledgements that skip packets twice in a row. A design that ignored repetition numbers would resend the same lost packets again on the second skip. It sends acknowledgements that are far outside the window or that fall after packet numbers have wrapped. A window compare done without modulo arithmetic would free the wrong slots or stall the ring. It lets the timeout expire with the oldest packet both pending and not pending, and it fills the ring until it is full. An off-by-one in the timer or in the full check shows up as a request one cycle late or as an overwritten live slot.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
    localparam int REP_W = 8;

    typedef struct packed {
        logic             pend;
        logic             acked;
        logic [REP_W-1:0] rep;
    } slot_t;

    function automatic logic [REP_W-1:0] rep_bump(input logic [REP_W-1:0] r);
        return (r == '1) ? r : r + REP_W'(1);
    endfunction
endpackage

// File: rtl/rdm_first_set.sv
module rdm_first_set #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rdm_timer.sv
module rdm_timer #(
    parameter int LIMIT = 1024,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && !clear && (cnt_q == CW'(LIMIT - 1));
        if (!run || clear || expire) cnt_d = '0;
        else                         cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/retx_desc_mgr.sv
module retx_desc_mgr
    import rdm_pkg::*;
#(
    parameter int NUM_SLOTS   = 32,
    parameter int PKT_W       = 16,
    parameter int TIMEOUT_CYC = 1024,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int CNT_W      = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_i,
    output logic              free_rdy_o,
    input  logic              ack_vld_i,
    input  logic [PKT_W-1:0]  ack_pkt_i,
    input  logic [REP_W-1:0]  ack_rep_i,
    output logic              tx_req_o,
    input  logic              tx_take_i,
    output logic [SLOT_W-1:0] tx_slot_o,
    output logic [PKT_W-1:0]  tx_pkt_o,
    output logic [REP_W-1:0]  tx_rep_o
);
    typedef struct packed {
        logic [PKT_W-1:0]            head;
        logic [PKT_W-1:0]            tail;
        slot_t [NUM_SLOTS-1:0]       slots;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0]     in_flight;
    logic [PKT_W-1:0]     oldest_pkt;
    logic [SLOT_W-1:0]    tail_slot;
    logic [SLOT_W-1:0]    head_slot;
    logic [SLOT_W-1:0]    ack_slot;
    logic [PKT_W-1:0]     ack_off;
    logic                 ack_hit;
    logic                 fill_ok;
    logic                 expire;
    logic [SLOT_W-1:0]    pos_slot [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] pend_ord;
    logic [NUM_SLOTS-1:0] live_ord;
    logic                 tx_found;
    logic [SLOT_W-1:0]    tx_pos;
    logic                 live_found;
    logic [SLOT_W-1:0]    live_pos;
    logic [CNT_W-1:0]     adv;

    assign in_flight  = CNT_W'(st_q.head - st_q.tail);
    assign oldest_pkt = st_q.tail;
    assign tail_slot  = st_q.tail[SLOT_W-1:0];
    assign head_slot  = st_q.head[SLOT_W-1:0];
    assign ack_slot   = ack_pkt_i[SLOT_W-1:0];
    assign free_rdy_o = in_flight < CNT_W'(NUM_SLOTS);
    assign fill_ok    = fill_i && free_rdy_o;

    // Window-ordered views of the ring: position 0 is the oldest packet.
    always_comb begin
        ack_off = ack_pkt_i - st_q.tail;
        ack_hit = ack_vld_i && (ack_off < PKT_W'(in_flight));
        for (int i = 0; i < NUM_SLOTS; i++) begin
            pos_slot[i] = tail_slot + SLOT_W'(i);
            pend_ord[i] = (CNT_W'(i) < in_flight) && st_q.slots[pos_slot[i]].pend;
            live_ord[i] = (CNT_W'(i) >= in_flight) ||
                          !(st_q.slots[pos_slot[i]].acked ||
                            (ack_hit && (ack_slot == pos_slot[i])));
        end
    end

    rdm_first_set #(.W(NUM_SLOTS), .IW(SLOT_W)) u_pick_tx (
        .vec   (pend_ord),
        .found (tx_found),
        .idx   (tx_pos)
    );

    rdm_first_set #(.W(NUM_SLOTS), .IW(SLOT_W)) u_pick_live (
        .vec   (live_ord),
        .found (live_found),
        .idx   (live_pos)
    );

    rdm_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_flight != '0),
        .clear  (ack_hit),
        .expire (expire)
    );

    assign tx_req_o  = tx_found;
    assign tx_slot_o = tail_slot + tx_pos;
    assign tx_pkt_o  = st_q.tail + PKT_W'(tx_pos);
    assign tx_rep_o  = st_q.slots[tx_slot_o].rep;
    assign adv       = live_found ? CNT_W'(live_pos) : CNT_W'(NUM_SLOTS);

    always_comb begin
        st_d = st_q;

        if (tx_found && tx_take_i) st_d.slots[tx_slot_o].pend = 1'b0;

        if (ack_hit) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if ((PKT_W'(i) < ack_off) &&
                    !st_q.slots[pos_slot[i]].acked &&
                    !st_q.slots[pos_slot[i]].pend &&
                    (st_q.slots[pos_slot[i]].rep <= ack_rep_i)) begin
                    st_d.slots[pos_slot[i]].pend = 1'b1;
                    st_d.slots[pos_slot[i]].rep  = rep_bump(st_q.slots[pos_slot[i]].rep);
                end
            end
            st_d.slots[ack_slot].acked = 1'b1;
            st_d.slots[ack_slot].pend  = 1'b0;
        end

        if (expire && !st_q.slots[tail_slot].pend) begin
            st_d.slots[tail_slot].pend = 1'b1;
            st_d.slots[tail_slot].rep  = rep_bump(st_q.slots[tail_slot].rep);
        end

        if (fill_ok) begin
            st_d.slots[head_slot].pend  = 1'b1;
            st_d.slots[head_slot].acked = 1'b0;
            st_d.slots[head_slot].rep   = '0;
            st_d.head                   = st_q.head + PKT_W'(1);
        end

        st_d.tail = st_q.tail + PKT_W'(adv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/retx_desc_mgr_chk.sv
module retx_desc_mgr_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int PKT_W     = 16,
    parameter int CNT_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fill_i,
    input logic             free_rdy_o,
    input logic             ack_vld_i,
    input logic [PKT_W-1:0] ack_pkt_i,
    input logic             tx_req_o,
    input logic             tx_take_i,
    input logic [CNT_W-1:0] in_flight,
    input logic [PKT_W-1:0] oldest_pkt
);
    logic             fill_acc;
    logic [PKT_W-1:0] rel;
    logic             outside;

    assign fill_acc = fill_i && free_rdy_o;
    assign rel      = ack_pkt_i - oldest_pkt;
    assign outside  = rel >= PKT_W'(in_flight);

    // R1: nothing outstanding means nothing to send
    p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight == '0) |-> !tx_req_o);

    // R2: an accepted fill adds exactly one outstanding packet
    p_fill_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_acc && !ack_vld_i) |=> (in_flight == $past(in_flight) + CNT_W'(1)));

    // R3: an untaken request persists when no acknowledgement intervenes
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_o && !tx_take_i && !ack_vld_i) |=> tx_req_o);

    // R7: acknowledgement outside the window frees nothing
    p_ignore_far_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld_i && outside && !fill_acc) |=> (in_flight == $past(in_flight)));

    // R9: the ring never holds more than its slot count
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight <= CNT_W'(NUM_SLOTS));
endmodule

bind retx_desc_mgr retx_desc_mgr_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .PKT_W     (PKT_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_i     (fill_i),
    .free_rdy_o (free_rdy_o),
    .ack_vld_i  (ack_vld_i),
    .ack_pkt_i  (ack_pkt_i),
    .tx_req_o   (tx_req_o),
    .tx_take_i  (tx_take_i),
    .in_flight  (in_flight),
    .oldest_pkt (oldest_pkt)
);

// File: tb/retx_desc_mgr_tb.sv
module retx_desc_mgr_tb;
    localparam int N     = 16;
    localparam int PW    = 6;
    localparam int TO    = 40;
    localparam int PMASK = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill = 1'b0;
    logic          take = 1'b0;
    logic          ack_vld = 1'b0;
    logic [PW-1:0] ack_pkt = '0;
    logic [7:0]    ack_rep = '0;
    logic          free_rdy, tx_req;
    logic [3:0]    tx_slot;
    logic [PW-1:0] tx_pkt;
    logic [7:0]    tx_rep;

    always #10 clk = ~clk;

    retx_desc_mgr #(.NUM_SLOTS(N), .PKT_W(PW), .TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .fill_i(fill), .free_rdy_o(free_rdy),
        .ack_vld_i(ack_vld), .ack_pkt_i(ack_pkt), .ack_rep_i(ack_rep),
        .tx_req_o(tx_req), .tx_take_i(take), .tx_slot_o(tx_slot),
        .tx_pkt_o(tx_pkt), .tx_rep_o(tx_rep)
    );

    typedef struct {
        int pkt;
        bit pend;
        bit acked;
        int rep;
    } rec_t;

    rec_t  q[$];
    int    mhead = 0;
    int    mtmr  = 0;
    int    n_chk = 0;
    int    n_err = 0;
    int    cycles = 0;
    bit    done = 0;
    string tag = "R1";

    function automatic int first_pend(input rec_t v[$]);
        for (int i = 0; i < v.size(); i++) if (v[i].pend) return i;
        return -1;
    endfunction

    function automatic int bump(input int r);
        return (r < 255) ? r + 1 : 255;
    endfunction

    task automatic model_step();
        rec_t q0[$];
        int   k;
        int   off;
        bit   hit;
        bit   exp_t;
        q0  = q;
        k   = first_pend(q0);
        hit = 0;
        off = 0;
        if (k >= 0 && take) q[k].pend = 0;
        if (ack_vld && q0.size() > 0) begin
            off = (int'(ack_pkt) - q0[0].pkt) & PMASK;
            hit = off < q0.size();
        end
        if (hit) begin
            for (int i = 0; i < off; i++)
                if (!q0[i].acked && !q0[i].pend && q0[i].rep <= int'(ack_rep)) begin
                    q[i].pend = 1;
                    q[i].rep  = bump(q0[i].rep);
                end
            q[off].acked = 1;
            q[off].pend  = 0;
        end
        exp_t = q0.size() > 0 && !hit && mtmr == TO - 1;
        if (q0.size() == 0 || hit || exp_t) mtmr = 0;
        else                                mtmr++;
        if (exp_t && !q0[0].pend) begin
            q[0].pend = 1;
            q[0].rep  = bump(q0[0].rep);
        end
        if (fill && q0.size() < N) begin
            q.push_back('{mhead, 1'b1, 1'b0, 0});
            mhead = (mhead + 1) & PMASK;
        end
        while (q.size() > 0 && q[0].acked) void'(q.pop_front());
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            mhead = 0;
            mtmr  = 0;
        end else begin
            model_step();
        end
    end

    task automatic chk(input string what, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_err++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp_v);
        end
    endtask

    // compare against the model away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int k;
            k = first_pend(q);
            chk("free_rdy", int'(free_rdy), int'(q.size() < N));
            chk("tx_req", int'(tx_req), int'(k >= 0));
            if (k >= 0) begin
                chk("tx_pkt", int'(tx_pkt), q[k].pkt);
                chk("tx_slot", int'(tx_slot), q[k].pkt % N);
                chk("tx_rep", int'(tx_rep), q[k].rep);
            end
        end
    end

    task automatic step(input bit f, input bit t, input bit av, input int ap, input int ar);
        fill    = f;
        take    = t;
        ack_vld = av;
        ack_pkt = PW'(ap & PMASK);
        ack_rep = 8'(ar);
        @(posedge clk);
        #2;
    endtask

    task automatic finish_up();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: idle state straight after reset
        tag = "R1";
        @(negedge clk);
        chk("reset free_rdy", int'(free_rdy), 1);
        chk("reset tx_req", int'(tx_req), 0);
        @(posedge clk); #2;

        // R2: five fills, framer not taking yet
        tag = "R2";
        repeat (5) step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);

        // R3: ordered transmission, held while not taken
        tag = "R3";
        repeat (3) step(0, 1, 0, 0, 0);
        repeat (2) step(0, 0, 0, 0, 0);
        repeat (3) step(0, 1, 0, 0, 0);

        // R5: ack of packet 2 skips 0 and 1
        tag = "R5";
        step(0, 0, 1, 2, 0);
        repeat (2) step(0, 0, 0, 0, 0);
        repeat (3) step(0, 1, 0, 0, 0);

        // R6: second skip with lower echoed repetition resends nothing
        tag = "R6";
        step(0, 1, 1, 3, 0);
        repeat (3) step(0, 1, 0, 0, 0);

        // R7: acknowledgement far outside the window
        tag = "R7";
        step(0, 1, 1, 40, 5);
        repeat (2) step(0, 1, 0, 0, 0);

        // R4: confirm the rest; oldest pointer jumps over confirmed packets
        tag = "R4";
        step(0, 1, 1, 1, 1);
        repeat (2) step(0, 1, 0, 0, 0);
        step(0, 1, 1, 0, 2);
        step(0, 1, 1, 4, 0);
        repeat (3) step(0, 1, 0, 0, 0);

        // R8: silence on the acknowledgement path
        tag = "R8";
        repeat (2) step(1, 1, 0, 0, 0);
        repeat (60) step(0, 1, 0, 0, 0);
        repeat (30) step(0, 0, 0, 0, 0);
        repeat (20) step(0, 1, 0, 0, 0);
        repeat (4) step(0, 1, q.size() > 0, q.size() > 0 ? q[0].pkt : 0, 9);

        // R9: fill until the ring is full, then drain in order
        tag = "R9";
        repeat (22) step(1, 1, 0, 0, 0);
        repeat (20) step(1, 1, q.size() > 0, q.size() > 0 ? q[0].pkt : 0, 9);
        repeat (18) step(0, 1, q.size() > 0, q.size() > 0 ? q[0].pkt : 0, 9);

        // R2: long mixed traffic so packet numbers wrap many times
        tag = "R2";
        for (int c = 0; c < 4000; c++) begin
            int base;
            base = (q.size() > 0) ? q[0].pkt : mhead;
            step(($urandom % 3) != 0, ($urandom % 2) != 0, ($urandom % 3) == 0,
                 base + int'($urandom % (N + 4)), int'($urandom % 4));
        end
        step(0, 0, 0, 0, 0);
        finish_up();
    end
endmodule